// File: doc/BRIEF.md
# Brown-out reset sequencer

This block is the digital half of a supply supervisor for a small microcontroller. An analog comparator reports, through a single flag, whether the supply sits below the selected brown-out trip point. The sequencer ignores short dips on that flag. It raises an active-high internal reset once the flag has stayed high long enough. After the supply recovers, it keeps the reset high for an optional power-up hold time. It also tells the comparator which of two trip points to use.

Detection can be always on, on only while the core is awake, or off. A flash erase overrides all of these: detection is forced on and the lowest trip point is selected. Time is measured in clock ticks. `FILT_TICKS` sets the dip filter and `PWRT_TICKS` sets the power-up hold. The nominal hold is 64 ms, so the integrator sets `PWRT_TICKS` to 64 ms divided by the clock period.

Top module: `bor_sequencer`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `sys_rst_o` and `trip_sel_o` are both 0.
- R2: With `erase_i` low, detection is active when `en_mode_i` is 2'b11. It is active for 2'b10 only while `sleep_i` is 0. It is inactive for 2'b00 and 2'b01. While detection is inactive, no brown-out event starts and `sys_rst_o` stays 0 however long `below_i` is high.
- R3: `trip_sel_o` follows `level_sel_i` one clock later. A value of 1 requests the higher trip point and 0 requests the lower trip point.
- R4: With detection active, `sys_rst_o` goes to 1 on the clock edge that samples `below_i` high for the (FILT_TICKS+1)-th consecutive time. Any run of FILT_TICKS or fewer high samples leaves `sys_rst_o` at 0.
- R5: A single low sample of `below_i` clears the dip filter, so two short runs separated by one low sample do not add up.
- R6: With `pwrt_bypass_i` = 0, after the first low sample of `below_i` during reset, `sys_rst_o` stays 1 for PWRT_TICKS more edges and drops to 0 on the edge after that (PWRT_TICKS+1 edges after the low sample).
- R7: With `pwrt_bypass_i` = 1, `sys_rst_o` drops to 0 on the edge that first samples `below_i` low.
- R8: If `below_i` is sampled high while detection is active during the power-up hold, the block returns to brown-out reset and the hold restarts in full from the next recovery. `sys_rst_o` stays 1 throughout.
- R9: While `erase_i` is 1, detection is active whatever `en_mode_i` and `sleep_i` are, and `trip_sel_o` is 0 one clock later.
- R10: If detection becomes inactive during brown-out reset, `sys_rst_o` drops on the next edge. If it becomes inactive during the power-up hold, the hold runs to its normal end and dips are ignored. In both cases the block then monitors without starting a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_i | input | 1 | Comparator flag: supply is below the trip point |
| en_mode_i | input | 2 | Detection mode (11 on, 10 on while awake, 0x off) |
| level_sel_i | input | 1 | Requested trip point (1 higher, 0 lower) |
| pwrt_bypass_i | input | 1 | 1 skips the power-up hold, 0 applies it |
| sleep_i | input | 1 | Core is in sleep |
| erase_i | input | 1 | Flash erase in progress |
| sys_rst_o | output | 1 | Registered internal reset, active high |
| trip_sel_o | output | 1 | Registered trip-point select to the comparator |

## Verification
Every result is a registered output, so each one has a fixed distance in clock edges from the stimulus that causes it. The select output is due one edge after its input. The reset rises FILT_TICKS+1 edges after the first high sample, and it falls PWRT_TICKS+1 edges after recovery, or one edge after recovery when the hold is bypassed. The driver converts each of these offsets into an absolute cycle number when it applies the stimulus. It queues the expected value under that number. The monitor compares only on that cycle, one time unit after the edge. Checks are also queued on the last cycle before each transition, so an edge that comes early or late is caught, not only a wrong level.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {
    ST_MON  = 2'd0,
    ST_FILT = 2'd1,
    ST_HOLD = 2'd2,
    ST_PWRT = 2'd3
  } bor_state_t;

  localparam logic TRIP_LOW = 1'b0;
endpackage

// File: rtl/bor_mode.sv
module bor_mode
  import bor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] en_mode_i,
  input  logic       sleep_i,
  input  logic       erase_i,
  input  logic       level_sel_i,
  output logic       active_o,
  output logic       trip_sel_o
);
  logic mode_on;

  always_comb begin
    unique case (en_mode_i)
      2'b11:   mode_on = 1'b1;
      2'b10:   mode_on = ~sleep_i;
      default: mode_on = 1'b0;
    endcase
    active_o = erase_i | mode_on;
  end

  always_ff @(posedge clk) begin
    if (rst)          trip_sel_o <= TRIP_LOW;
    else if (erase_i) trip_sel_o <= TRIP_LOW;
    else              trip_sel_o <= level_sel_i;
  end

  p_erase_low_trip_r9: assert property (@(posedge clk) disable iff (rst)
    erase_i |=> (trip_sel_o == TRIP_LOW));
  p_sel_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !erase_i |=> (trip_sel_o == $past(level_sel_i)));
endmodule

// File: rtl/bor_counter.sv
module bor_counter #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit_o = run_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || hit_o) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt == '0));
endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer
  import bor_pkg::*;
#(
  parameter int unsigned FILT_TICKS = 8,
  parameter int unsigned PWRT_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       below_i,
  input  logic [1:0] en_mode_i,
  input  logic       level_sel_i,
  input  logic       pwrt_bypass_i,
  input  logic       sleep_i,
  input  logic       erase_i,
  output logic       sys_rst_o,
  output logic       trip_sel_o
);
  bor_state_t state, state_nx;
  logic active, dip;
  logic filt_run, filt_hit;
  logic pwrt_run, pwrt_hit;

  bor_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .en_mode_i  (en_mode_i),
    .sleep_i    (sleep_i),
    .erase_i    (erase_i),
    .level_sel_i(level_sel_i),
    .active_o   (active),
    .trip_sel_o (trip_sel_o)
  );

  assign dip      = active & below_i;
  assign filt_run = (state == ST_FILT) & dip;
  assign pwrt_run = (state == ST_PWRT) & ~dip;

  bor_counter #(.LIMIT(FILT_TICKS)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .run_i(filt_run),
    .hit_o(filt_hit)
  );

  bor_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk  (clk),
    .rst  (rst),
    .run_i(pwrt_run),
    .hit_o(pwrt_hit)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_MON:  if (dip) state_nx = ST_FILT;
      ST_FILT: begin
        if (!dip)         state_nx = ST_MON;
        else if (filt_hit) state_nx = ST_HOLD;
      end
      ST_HOLD: begin
        if (!active)             state_nx = ST_MON;
        else if (!below_i)       state_nx = pwrt_bypass_i ? ST_MON : ST_PWRT;
      end
      ST_PWRT: begin
        if (dip)           state_nx = ST_HOLD;
        else if (pwrt_hit) state_nx = ST_MON;
      end
      default: state_nx = ST_MON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_MON;
      sys_rst_o <= 1'b0;
    end else begin
      state     <= state_nx;
      sys_rst_o <= (state_nx == ST_HOLD) || (state_nx == ST_PWRT);
    end
  end

  p_rise_needs_dip_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> ($past(below_i) && $past(active)));
  p_idle_stays_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!active && !sys_rst_o) |=> !sys_rst_o);
  p_hold_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && active && !below_i && pwrt_bypass_i) |=> !sys_rst_o);
  p_redip_back_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWRT && dip) |=> (state == ST_HOLD && sys_rst_o));
  p_hold_off_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !active) |=> !sys_rst_o);
endmodule

// File: tb/sim_bor_sequencer.sv
module sim_bor_sequencer;
  localparam int F = 8;
  localparam int P = 32;

  typedef struct {
    int   cyc;
    bit   is_sel;
    logic val;
    int   req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below = 1'b0;
  logic [1:0] mode = 2'b11;
  logic lvl = 1'b0;
  logic byp = 1'b0;
  logic slp = 1'b0;
  logic ers = 1'b0;
  logic sys_rst, trip_sel;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bor_sequencer #(.FILT_TICKS(F), .PWRT_TICKS(P)) u0 (
    .clk(clk), .rst(rst), .below_i(below), .en_mode_i(mode),
    .level_sel_i(lvl), .pwrt_bypass_i(byp), .sleep_i(slp), .erase_i(ers),
    .sys_rst_o(sys_rst), .trip_sel_o(trip_sel)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_rst(int d, logic v, int req);
    q.push_back('{cyc + d, 1'b0, v, req});
  endtask

  task automatic exp_sel(int d, logic v, int req);
    q.push_back('{cyc + d, 1'b1, v, req});
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t it;
      logic act;
      it = q.pop_front();
      act = it.is_sel ? trip_sel : sys_rst;
      checks++;
      if (act !== it.val || it.cyc != cyc) begin
        errors++;
        $display("FAIL R%0d %s at cycle %0d: actual=%b expected=%b",
                 it.req, it.is_sel ? "trip_sel_o" : "sys_rst_o", cyc, act, it.val);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: values under reset and just after release
    exp_rst(1, 1'b0, 1); exp_sel(1, 1'b0, 1);
    rst = 1'b0;
    exp_rst(1, 1'b0, 1); exp_sel(1, 1'b0, 1);
    tick(3);

    // R4: a dip of exactly F samples does not reset
    below = 1'b1;
    exp_rst(F, 1'b0, 4);
    tick(F);
    below = 1'b0;
    exp_rst(1, 1'b0, 4);
    tick(3);

    // R5: two F-sample dips split by one low sample do not add up
    below = 1'b1; tick(F);
    below = 1'b0; tick(1);
    below = 1'b1;
    exp_rst(F, 1'b0, 5);
    tick(F);
    below = 1'b0;
    exp_rst(1, 1'b0, 5); exp_rst(2, 1'b0, 5);
    tick(3);

    // R4: a sustained dip resets on the (F+1)th high sample
    below = 1'b1;
    exp_rst(F, 1'b0, 4); exp_rst(F + 1, 1'b1, 4);
    tick(F + 5);

    // R6: power-up hold after recovery
    below = 1'b0;
    exp_rst(P, 1'b1, 6); exp_rst(P + 1, 1'b0, 6);
    tick(P + 4);

    // R8: re-dip during the hold restarts it
    below = 1'b1; tick(F + 3);
    below = 1'b0; tick(10);
    below = 1'b1;
    exp_rst(1, 1'b1, 8);
    tick(1);
    below = 1'b0;
    exp_rst(P, 1'b1, 8); exp_rst(P + 1, 1'b0, 8);
    tick(P + 4);

    // R7: bypassed hold releases on the recovery edge
    byp = 1'b1;
    below = 1'b1;
    exp_rst(F + 1, 1'b1, 7);
    tick(F + 3);
    below = 1'b0;
    exp_rst(1, 1'b0, 7);
    tick(3);

    // R2: mode 10 asleep ignores a long dip, then detects once awake
    mode = 2'b10; slp = 1'b1; below = 1'b1;
    exp_rst(F + 2, 1'b0, 2); exp_rst(2 * F, 1'b0, 2);
    tick(2 * F + 2);
    slp = 1'b0;
    exp_rst(F, 1'b0, 2); exp_rst(F + 1, 1'b1, 2);
    tick(F + 3);
    below = 1'b0;
    exp_rst(1, 1'b0, 7);
    tick(3);
    // R2: modes 00 and 01 are off
    mode = 2'b00; below = 1'b1;
    exp_rst(2 * F, 1'b0, 2);
    tick(2 * F + 1);
    mode = 2'b01;
    exp_rst(2 * F, 1'b0, 2);
    tick(2 * F + 1);
    below = 1'b0;
    tick(2);

    // R3: select follows its input one clock later
    mode = 2'b00; lvl = 1'b1;
    exp_sel(1, 1'b1, 3);
    tick(2);
    // R9: erase forces low trip and detection despite mode 00
    ers = 1'b1; below = 1'b1;
    exp_sel(1, 1'b0, 9);
    exp_rst(F, 1'b0, 9); exp_rst(F + 1, 1'b1, 9);
    tick(F + 3);
    // R10: detection off during reset releases on the next edge
    ers = 1'b0;
    exp_rst(1, 1'b0, 10); exp_sel(1, 1'b1, 3);
    exp_rst(F + 4, 1'b0, 10);
    tick(F + 5);
    below = 1'b0; byp = 1'b0; lvl = 1'b0;
    tick(2);

    // R10: detection off during the hold lets it finish, dips ignored
    mode = 2'b11; below = 1'b1;
    tick(F + 3);
    below = 1'b0;
    tick(5);
    mode = 2'b00; below = 1'b1;
    exp_rst(P - 5, 1'b1, 10); exp_rst(P - 4, 1'b0, 10);
    exp_rst(P + 10, 1'b0, 10);
    tick(P + 12);
    below = 1'b0;

    while (q.size() > 0) tick(1);
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule